// File: doc/BRIEF.md
# DMA Request Sampling Handshake Controller

This block watches the external request line of one DMA channel and decides when that channel may take a bus cycle. It sends a one-clock request-acknowledge pulse for each sample that finds a request. It raises a grant towards a simple bus-cycle sequencer once the minimum lead time after that sample has passed. During granted cycles it drives a transfer-acknowledge strobe, and it marks the dummy cycle that burst single-address level-triggered transfers need. The request is not sampled on every clock. While a transfer is pending, it is sampled when the sequencer announces the next bus cycle. Sampling falls back to every clock only after a sample point misses, or when nothing is pending.

The sequencer pulses `cyc_start` in the clock before a bus cycle begins and `cyc_end` in its last clock. A cycle announced while `dma_go` is high is the DMA cycle. The next cycle may be announced in the same clock as `cyc_end`. Mode inputs are changed only while `chan_en` is low.

Top module: `dreq_sampler`

## Requirements
- R1: The request is active low. In level mode a sample detects a request when `req_n` is 0 in that clock. In edge mode a sample detects one only when `req_n` is 0 and was 1 in the previous clock. The previous value follows the pin even while the channel is disabled, so a line already held low at enable is not a request in edge mode.
- R2: `req_ack` is high for exactly the one clock after an edge whose sample detected a request. Samples that miss, and a request held low between sample points, produce no pulse.
- R3: `dma_go` rises no earlier than the third rising edge after the detecting edge. It then stays high until the sequencer announces a cycle.
- R4: While a transfer is pending, the announcement of a non-DMA bus cycle is a sample point. A request found there is queued behind the pending one.
- R5: When a sample point misses, or when no transfer is pending, the request is sampled on every clock until one is detected.
- R6: At most one request is queued behind the pending one. A queued request also obeys the three-edge minimum of R3, counted from its own detecting edge.
- R7: With `single_addr`=1, `xfer_ack` is high from the clock after a DMA cycle is announced through the clock carrying `cyc_end`. With `single_addr`=0 it stays low.
- R8: In burst mode with edge detection (`burst_mode`=1, `level_det`=0), only the first detected request after enable is sampled and acknowledged. Transfers then repeat with `dma_go` held high for as long as the channel stays enabled.
- R9: In burst mode with level detection, the announcement of a DMA cycle is itself a sample point, so transfers continue while the request stays low. A miss there leaves nothing pending.
- R10: In burst mode with single address and level detection, the first granted cycle after the first detection since enable is a dummy. `dummy_cyc` covers that cycle, `xfer_ack` stays low, and the request remains pending for the next grant.
- R11: With `chan_en` low (or in reset), every output is low from the next clock and all pending, queued and first-sample state is cleared. After re-enabling, the next detected request is again treated as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; low clears all state |
| burst_mode | input | 1 | 1 = burst, 0 = cycle steal |
| single_addr | input | 1 | 1 = single-address, 0 = dual-address |
| level_det | input | 1 | 1 = low-level detection, 0 = falling-edge detection |
| req_n | input | 1 | External DMA request, active low |
| cyc_start | input | 1 | Next bus cycle begins after this clock |
| cyc_end | input | 1 | Last clock of the current bus cycle |
| req_ack | output | 1 | One-clock request-acknowledge pulse |
| xfer_ack | output | 1 | Transfer acknowledge during single-address DMA cycles |
| dma_go | output | 1 | Next announced cycle may be a DMA cycle |
| dummy_cyc | output | 1 | Current cycle is a dummy; its data is undefined |

## Verification
Cycle-steal level detection is driven with the request held low throughout. This separates the sample point at a cycle announcement from every-clock sampling, and a sampler that acknowledged on each clock would stand out. Edge detection is tried with a line held low across enable and with a falling edge after a missed sample point, which tells a true edge detector from a level check. Burst runs are tried with the request toggling during edge mode, where nothing may be re-acknowledged, and with a request that is held low and then released during level mode. These runs expose the dummy slot, back-to-back grants and the fall-back to every-clock sampling. The grant edge is checked on the exact clock for both a fresh and a queued request.

// File: rtl/dreq_sampler.sv
`timescale 1ns/1ps
module dreq_sampler #(
  parameter int unsigned LEAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic burst_mode,
  input  logic single_addr,
  input  logic level_det,
  input  logic req_n,
  input  logic cyc_start,
  input  logic cyc_end,
  output logic req_ack,
  output logic xfer_ack,
  output logic dma_go,
  output logic dummy_cyc
);
  localparam int unsigned AW = $clog2(LEAD + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(LEAD);

  logic req_q, pend_q, nxt_q, open_q, once_q, dum_due_q, xack_q, dum_q, ack_q;
  logic [AW-1:0] age_q, nage_q;

  logic burst_lvl, burst_edge;
  assign burst_lvl  = burst_mode & level_det;
  assign burst_edge = burst_mode & ~level_det;

  // grant decode and cycle classification
  logic grant, start, dum_start, real_start, consume;
  assign grant      = pend_q & (age_q == AGE_MAX);
  assign start      = cyc_start & grant;
  assign dum_start  = start & dum_due_q;
  assign real_start = start & ~dum_due_q;
  assign consume    = real_start & ~burst_edge;

  // slot state once the started transfer is retired
  logic [AW-1:0] age_inc, nage_inc, a1;
  logic p1, q1;
  assign age_inc  = (age_q  == AGE_MAX) ? age_q  : age_q  + 1'b1;
  assign nage_inc = (nage_q == AGE_MAX) ? nage_q : nage_q + 1'b1;
  assign p1 = consume ? nxt_q : pend_q;
  assign q1 = consume ? 1'b0  : nxt_q;
  assign a1 = consume ? nage_inc : age_inc;

  // sampling
  logic spt, samp, low_seen, hit, miss;
  assign spt      = cyc_start & pend_q & ~dum_start & (~start | burst_lvl);
  assign samp     = chan_en & ~(p1 & q1) & ~(burst_edge & once_q) & (open_q | spt);
  assign low_seen = level_det ? ~req_n : (req_q & ~req_n);
  assign hit      = samp & low_seen;
  assign miss     = samp & ~low_seen;

  logic pend_n, nxt_n;
  assign pend_n = p1 | hit;
  assign nxt_n  = q1 | (hit & p1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; nxt_q <= 1'b0; open_q <= 1'b1; once_q <= 1'b0;
      dum_due_q <= 1'b0; xack_q <= 1'b0; dum_q <= 1'b0; ack_q <= 1'b0;
      age_q <= '0; nage_q <= '0;
    end else if (!chan_en) begin
      pend_q <= 1'b0; nxt_q <= 1'b0; open_q <= 1'b1; once_q <= 1'b0;
      dum_due_q <= 1'b0; xack_q <= 1'b0; dum_q <= 1'b0; ack_q <= 1'b0;
      age_q <= '0; nage_q <= '0;
    end else begin
      pend_q    <= pend_n;
      nxt_q     <= nxt_n;
      age_q     <= (hit & ~p1) ? '0 : a1;
      nage_q    <= (hit & p1 | consume) ? '0 : nage_inc;
      open_q    <= ~hit & (open_q | miss | ~pend_n);
      once_q    <= once_q | hit;
      dum_due_q <= (dum_due_q & ~dum_start) | (hit & ~once_q & burst_lvl & single_addr);
      xack_q    <= (real_start & single_addr) | (xack_q & ~cyc_end);
      dum_q     <= dum_start | (dum_q & ~cyc_end);
      ack_q     <= hit;
    end
  end

  assign req_ack   = ack_q;
  assign xfer_ack  = xack_q;
  assign dma_go    = grant;
  assign dummy_cyc = dum_q;

  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !req_ack && !xfer_ack && !dma_go && !dummy_cyc);
  p_dummy_no_xack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_cyc |-> !xfer_ack);
  p_xack_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> single_addr);
  p_xack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && xfer_ack && !cyc_end |=> xfer_ack);
  p_edge_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && burst_mode && !level_det && once_q |=> !req_ack);
  p_grant_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && dma_go && !cyc_start |=> dma_go);
endmodule

// File: tb/dreq_sampler_test.sv
`timescale 1ns/1ps
module dreq_sampler_test;
  logic clk = 1'b0;
  logic rst_n, chan_en, burst_mode, single_addr, level_det, req_n, cyc_start, cyc_end;
  logic req_ack, xfer_ack, dma_go, dummy_cyc;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dreq_sampler uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .burst_mode(burst_mode),
    .single_addr(single_addr), .level_det(level_det), .req_n(req_n),
    .cyc_start(cyc_start), .cyc_end(cyc_end), .req_ack(req_ack),
    .xfer_ack(xfer_ack), .dma_go(dma_go), .dummy_cyc(dummy_cyc)
  );

  task automatic step();
    @(posedge clk); #1;
    cyc_start = 1'b0; cyc_end = 1'b0;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic b, input logic s, input logic l);
    chan_en = 1'b0; step();
    burst_mode = b; single_addr = s; level_det = l; chan_en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chan_en = 1'b0; burst_mode = 1'b0; single_addr = 1'b0;
    level_det = 1'b0; req_n = 1'b1; cyc_start = 1'b0; cyc_end = 1'b0;
    step(); step(); rst_n = 1'b1; step();
    chk("R11 reset req_ack", req_ack, 1'b0);
    chk("R11 reset xfer_ack", xfer_ack, 1'b0);
    chk("R11 reset dma_go", dma_go, 1'b0);
    chk("R11 reset dummy_cyc", dummy_cyc, 1'b0);
  endtask

  task automatic t_level_steal();
    cfg(1'b0, 1'b1, 1'b1);
    req_n = 1'b0; step();
    chk("R2 ack after hit", req_ack, 1'b1);
    chk("R3 no grant at hit", dma_go, 1'b0);
    step();
    chk("R2 single pulse", req_ack, 1'b0);
    step();
    chk("R3 no grant edge 2", dma_go, 1'b0);
    step();
    chk("R3 grant edge 3", dma_go, 1'b1);
    chk("R2 held low not reacked", req_ack, 1'b0);
    cyc_start = 1'b1; step();
    chk("R7 xfer_ack starts", xfer_ack, 1'b1);
    chk("R3 grant taken", dma_go, 1'b0);
    chk("R2 no ack at DMA start", req_ack, 1'b0);
    step();
    chk("R5 every-clock sample hits", req_ack, 1'b1);
    chk("R7 xfer_ack held", xfer_ack, 1'b1);
    cyc_end = 1'b1; step();
    chk("R7 xfer_ack ends", xfer_ack, 1'b0);
    step();
    chk("R3 queued-free grant early", dma_go, 1'b0);
    step();
    chk("R3 grant third edge", dma_go, 1'b1);
    req_n = 1'b1;
  endtask

  task automatic t_cpu_resample();
    cfg(1'b0, 1'b1, 1'b1);
    req_n = 1'b0; step();
    chk("R2 first hit", req_ack, 1'b1);
    req_n = 1'b1; step();
    req_n = 1'b0; step();
    chk("R4 no sample between points", req_ack, 1'b0);
    cyc_start = 1'b1; step();
    chk("R4 hit at CPU announcement", req_ack, 1'b1);
    chk("R3 grant with queue", dma_go, 1'b1);
    chk("R7 CPU cycle no xfer_ack", xfer_ack, 1'b0);
    req_n = 1'b1;
  endtask

  task automatic t_edge_steal();
    req_n = 1'b0;
    cfg(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R1 held low is no edge", req_ack, 1'b0);
    end
    req_n = 1'b1; step();
    req_n = 1'b0; step();
    chk("R1 falling edge detected", req_ack, 1'b1);
    cyc_start = 1'b1; step();
    chk("R4 miss at CPU announcement", req_ack, 1'b0);
    req_n = 1'b1; step();
    chk("R5 high is miss", req_ack, 1'b0);
    req_n = 1'b0; step();
    chk("R5 every-clock edge hit", req_ack, 1'b1);
    chk("R3 first grant", dma_go, 1'b1);
    cyc_start = 1'b1; step();
    chk("R7 dual no xfer_ack", xfer_ack, 1'b0);
    chk("R6 queued grant not yet", dma_go, 1'b0);
    cyc_end = 1'b1; step();
    chk("R6 queued grant edge 2", dma_go, 1'b0);
    step();
    chk("R6 queued grant edge 3", dma_go, 1'b1);
    req_n = 1'b1;
  endtask

  task automatic t_burst_edge();
    cfg(1'b1, 1'b0, 1'b0);
    req_n = 1'b1; step();
    req_n = 1'b0; step();
    chk("R8 first ack", req_ack, 1'b1);
    step(); step(); step();
    chk("R8 grant", dma_go, 1'b1);
    for (int i = 0; i < 8; i++) begin
      cyc_start = 1'b1; cyc_end = (i > 0); req_n = i[0]; step();
      chk("R8 grant continues", dma_go, 1'b1);
      chk("R8 no further ack", req_ack, 1'b0);
      chk("R7 dual burst xfer_ack low", xfer_ack, 1'b0);
    end
    req_n = 1'b1;
  endtask

  task automatic t_burst_level_single();
    cfg(1'b1, 1'b1, 1'b1);
    req_n = 1'b0; step();
    chk("R9 first ack", req_ack, 1'b1);
    step(); step(); step();
    chk("R9 first grant", dma_go, 1'b1);
    cyc_start = 1'b1; step();
    chk("R10 dummy flagged", dummy_cyc, 1'b1);
    chk("R10 no xfer_ack in dummy", xfer_ack, 1'b0);
    chk("R10 still pending", dma_go, 1'b1);
    chk("R10 no sample at dummy", req_ack, 1'b0);
    cyc_end = 1'b1; step();
    chk("R10 dummy ends", dummy_cyc, 1'b0);
    cyc_start = 1'b1; step();
    chk("R9 sample at DMA announcement", req_ack, 1'b1);
    chk("R7 single xfer_ack", xfer_ack, 1'b1);
    chk("R10 real cycle not dummy", dummy_cyc, 1'b0);
    chk("R9 new request aging", dma_go, 1'b0);
    cyc_end = 1'b1; step();
    step();
    chk("R9 grant edge 2", dma_go, 1'b0);
    step();
    chk("R9 grant edge 3", dma_go, 1'b1);
    req_n = 1'b1; cyc_start = 1'b1; step();
    chk("R9 miss leaves nothing", dma_go, 1'b0);
    chk("R9 last transfer acked", xfer_ack, 1'b1);
    chk("R9 no ack on miss", req_ack, 1'b0);
    cyc_end = 1'b1; step();
    chk("R7 xfer_ack released", xfer_ack, 1'b0);
    req_n = 1'b0; step();
    chk("R5 every clock after miss", req_ack, 1'b1);
  endtask

  task automatic t_disable();
    chan_en = 1'b0; step();
    chk("R11 ack cleared", req_ack, 1'b0);
    chk("R11 grant cleared", dma_go, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 no sample while off", req_ack, 1'b0);
    end
    chan_en = 1'b1; step();
    chk("R11 sampling after enable", req_ack, 1'b1);
    step(); step(); step();
    cyc_start = 1'b1; step();
    chk("R11 first-request state rearmed", dummy_cyc, 1'b1);
    cyc_end = 1'b1; req_n = 1'b1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_level_steal();
    t_cpu_resample();
    t_edge_steal();
    t_burst_edge();
    t_burst_level_single();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule